// File: doc/BRIEF.md
# 8-bit Accumulator ALU With Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. On every enabled clock edge it takes the current accumulator value, one 8-bit operand, the current five-bit flag word and a five-bit operation code. It stores the new accumulator value and the new flag word in one register stage. Fetching the operand and addressing memory happen outside the block.

Each operation has its own rule for which flags it rewrites and which it passes through unchanged. The flag word goes to the output either rewritten or as it came in. The surrounding control logic feeds the registered outputs back as the next accumulator and flag inputs.

Top module: `acc_alu`

## Requirements
- R1: An active-low reset `rst_n` clears `acc_q` and `flags_q` to zero. While `en` is low, both hold their values. While `en` is high, each rising clock edge loads the result of the selected operation.
- R2: The flag word is laid out as bit 4 sign (S), bit 3 zero (Z), bit 2 half carry (AC), bit 1 parity (P) and bit 0 carry (CY). Wherever S, Z and P are updated, S is bit 7 of the value, Z is set when the value is zero, and P is set when the value has an even number of 1 bits.
- R3: Code 0 adds the operand to the accumulator, and code 1 adds the operand plus CY. The sum is written to the accumulator. CY takes the carry out of bit 7, AC takes the carry out of bit 3, and S, Z and P follow the sum.
- R4: Code 2 subtracts the operand from the accumulator, and code 3 subtracts the operand plus CY. The difference is written to the accumulator. CY is set on a borrow out of bit 7, AC is set on a borrow out of bit 3, and S, Z and P follow the difference.
- R5: Code 4 compares the operand with the accumulator. The accumulator is kept unchanged. CY is set when the accumulator is below the operand and Z is set when they are equal, so both are clear when it is above. AC, S and P follow the difference of the two.
- R6: Codes 5 (AND), 6 (XOR) and 7 (OR) write the bitwise result to the accumulator. S, Z and P follow that result and CY is cleared. AND sets AC, while XOR and OR clear it.
- R7: Code 8 rotates left, copying bit 7 into bit 0 and into CY. Code 9 rotates right, copying bit 0 into bit 7 and into CY. Code 10 rotates left through carry, so bit 7 goes to CY and the old CY goes to bit 0. Code 11 rotates right through carry, so bit 0 goes to CY and the old CY goes to bit 7. Rotates leave S, Z, AC and P unchanged.
- R8: Code 12 inverts the accumulator and changes no flag. Code 13 inverts CY and code 14 sets CY. Both of these keep the accumulator and every other flag unchanged.
- R9: Code 15 adds one to the accumulator and code 16 subtracts one. Both keep CY unchanged and update S, Z and P. For increment, AC is set when the low nibble was 0xF. For decrement, AC is set when the low nibble was 0x0.
- R10: Code 17 is decimal adjust. If the low nibble exceeds 9 or AC is set, 6 is added to the accumulator. Then, if that addition carried out of bit 7, the new high nibble exceeds 9, or CY is set, 0x60 is added. AC becomes 1 when the low nibble exceeded 9. CY becomes 1 when the high correction was applied and otherwise keeps its value. S, Z and P follow the result.
- R11: Codes 18 to 31 load the accumulator input and the flag input unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable for the result register |
| op | input | 5 | Operation code |
| acc_in | input | 8 | Current accumulator value |
| opnd | input | 8 | Second operand |
| flags_in | input | 5 | Current flag word {S,Z,AC,P,CY} |
| acc_q | output | 8 | Registered accumulator result |
| flags_q | output | 5 | Registered flag result |

## Verification
Every operation code, including two unused ones, is swept over all 256 accumulator values. Each sweep uses four operands: zero, all ones, a copy of the accumulator and a scrambled value. The all-ones and equal operands separate carry from no carry and less-than from equal in compare. The four flag words are empty, full, CY alone and AC alone. These expose any operation that reads the wrong incoming flag or overwrites a flag it should pass through. Decimal adjust sees every nibble combination with AC and CY set both independently and together, which covers both the correction paths and the carry out of the low correction.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [4:0] op,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd,
  input  logic [4:0] flags_in,
  output logic [7:0] acc_q,
  output logic [4:0] flags_q
);
  localparam int FCY = 0, FP = 1, FAC = 2, FZ = 3, FS = 4;
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3;
  localparam logic [4:0] OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_XOR = 5'd6,  OP_OR  = 5'd7;
  localparam logic [4:0] OP_RLC = 5'd8,  OP_RRC = 5'd9,  OP_RAL = 5'd10, OP_RAR = 5'd11;
  localparam logic [4:0] OP_CMA = 5'd12, OP_CMC = 5'd13, OP_STC = 5'd14, OP_INC = 5'd15;
  localparam logic [4:0] OP_DEC = 5'd16, OP_DAA = 5'd17;

  wire       cy_in = flags_in[FCY];
  wire       use_c = (op == OP_ADC) || (op == OP_SBB);
  wire [8:0] cx    = {8'd0, use_c & cy_in};

  wire [8:0] sum   = {1'b0, acc_in} + {1'b0, opnd} + cx;
  wire [4:0] lsum  = {1'b0, acc_in[3:0]} + {1'b0, opnd[3:0]} + cx[4:0];
  wire [8:0] diff  = {1'b0, acc_in} - {1'b0, opnd} - cx;
  wire [4:0] ldiff = {1'b0, acc_in[3:0]} - {1'b0, opnd[3:0]} - cx[4:0];

  wire       lo_fix = (acc_in[3:0] > 4'd9) || flags_in[FAC];
  wire [8:0] da_t   = {1'b0, acc_in} + (lo_fix ? 9'd6 : 9'd0);
  wire       hi_fix = cy_in || da_t[8] || (da_t[7:4] > 4'd9);

  logic [7:0] res, val;
  logic [4:0] fo;
  logic       szp;

  always_comb begin
    res = acc_in;
    val = acc_in;
    fo  = flags_in;
    szp = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        res = sum[7:0];
        fo[FCY] = sum[8];
        fo[FAC] = lsum[4];
        szp = 1'b1;
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        if (op != OP_CMP) res = diff[7:0];
        val = diff[7:0];
        fo[FCY] = diff[8];
        fo[FAC] = ldiff[4];
        szp = 1'b1;
      end
      OP_AND: begin
        res = acc_in & opnd;
        fo[FCY] = 1'b0;
        fo[FAC] = 1'b1;
        szp = 1'b1;
      end
      OP_XOR, OP_OR: begin
        res = (op == OP_XOR) ? (acc_in ^ opnd) : (acc_in | opnd);
        fo[FCY] = 1'b0;
        fo[FAC] = 1'b0;
        szp = 1'b1;
      end
      OP_RLC: begin res = {acc_in[6:0], acc_in[7]}; fo[FCY] = acc_in[7]; end
      OP_RRC: begin res = {acc_in[0], acc_in[7:1]}; fo[FCY] = acc_in[0]; end
      OP_RAL: begin res = {acc_in[6:0], cy_in};     fo[FCY] = acc_in[7]; end
      OP_RAR: begin res = {cy_in, acc_in[7:1]};     fo[FCY] = acc_in[0]; end
      OP_CMA: res = ~acc_in;
      OP_CMC: fo[FCY] = ~cy_in;
      OP_STC: fo[FCY] = 1'b1;
      OP_INC: begin
        res = acc_in + 8'd1;
        fo[FAC] = (acc_in[3:0] == 4'hF);
        szp = 1'b1;
      end
      OP_DEC: begin
        res = acc_in - 8'd1;
        fo[FAC] = (acc_in[3:0] == 4'h0);
        szp = 1'b1;
      end
      OP_DAA: begin
        res = da_t[7:0] + (hi_fix ? 8'h60 : 8'h00);
        fo[FAC] = (acc_in[3:0] > 4'd9);
        fo[FCY] = hi_fix;
        szp = 1'b1;
      end
      default: ;
    endcase
    if (op != OP_CMP) val = res;
    if (szp) begin
      fo[FS] = val[7];
      fo[FZ] = (val == 8'd0);
      fo[FP] = ~^val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 8'd0;
      flags_q <= 5'd0;
    end else if (en) begin
      acc_q   <= res;
      flags_q <= fo;
    end
  end
endmodule

module acc_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [4:0] op,
  input logic [7:0] acc_in,
  input logic [7:0] opnd,
  input logic [4:0] flags_in,
  input logic [7:0] acc_q,
  input logic [4:0] flags_q
);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc_q) && $stable(flags_q)));

  a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 5'd4) |=> (acc_q == $past(acc_in)));

  a_r6_and_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 5'd5) |=> (flags_q[2] && !flags_q[0]));

  a_r7_rotate_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op >= 5'd8 && op <= 5'd11) |=> (flags_q[4:1] == $past(flags_in[4:1])));

  a_r8_cma_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 5'd12) |=> (flags_q == $past(flags_in) && acc_q == ~$past(acc_in)));

  a_r9_incdec_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == 5'd15 || op == 5'd16)) |=> (flags_q[0] == $past(flags_in[0])));

  a_r2_parity_add: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op <= 5'd1) |=> (flags_q[1] == ~^acc_q && flags_q[4] == acc_q[7]));

  a_r11_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op >= 5'd18) |=> (acc_q == $past(acc_in) && flags_q == $past(flags_in)));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc_in(acc_in), .opnd(opnd),
  .flags_in(flags_in), .acc_q(acc_q), .flags_q(flags_q)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] acc_in = 8'd0;
  logic [7:0] opnd = 8'd0;
  logic [4:0] flags_in = 5'd0;
  logic [7:0] acc_q;
  logic [4:0] flags_q;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc_in(acc_in), .opnd(opnd),
    .flags_in(flags_in), .acc_q(acc_q), .flags_q(flags_q)
  );

  function automatic string req_of(int o);
    if (o <= 1) return "R3";
    if (o <= 3) return "R4";
    if (o == 4) return "R5";
    if (o <= 7) return "R6";
    if (o <= 11) return "R7";
    if (o <= 14) return "R8";
    if (o <= 16) return "R9";
    if (o == 17) return "R10";
    return "R11";
  endfunction

  function automatic logic [12:0] model(int o, int a, int b, logic [4:0] f);
    int r, v, c, s, t;
    logic cy, ac, szp;
    r = a; v = a; cy = f[0]; ac = f[2]; szp = 1'b0;
    c = (o == 1 || o == 3) ? int'(f[0]) : 0;
    case (o)
      0, 1: begin
        s = a + b + c;
        cy = s > 255; ac = (a % 16 + b % 16 + c) > 15;
        r = s % 256; szp = 1'b1;
      end
      2, 3, 4: begin
        s = a - b - c;
        cy = s < 0; ac = (a % 16 - b % 16 - c) < 0;
        v = (s + 256) % 256;
        if (o != 4) r = v;
        szp = 1'b1;
      end
      5: begin r = a & b; cy = 0; ac = 1; szp = 1'b1; end
      6: begin r = a ^ b; cy = 0; ac = 0; szp = 1'b1; end
      7: begin r = a | b; cy = 0; ac = 0; szp = 1'b1; end
      8: begin cy = a >= 128; r = (a * 2) % 256 + (a / 128); end
      9: begin cy = a % 2; r = a / 2 + (a % 2) * 128; end
      10: begin r = (a * 2) % 256 + int'(f[0]); cy = a >= 128; end
      11: begin r = a / 2 + int'(f[0]) * 128; cy = a % 2; end
      12: r = 255 - a;
      13: cy = ~f[0];
      14: cy = 1'b1;
      15: begin r = (a + 1) % 256; ac = (a % 16) == 15; szp = 1'b1; end
      16: begin r = (a + 255) % 256; ac = (a % 16) == 0; szp = 1'b1; end
      17: begin
        t = a;
        if (a % 16 > 9 || f[2]) t = t + 6;
        ac = (a % 16) > 9;
        if (f[0] || t > 255 || (t / 16) % 16 > 9) begin
          t = t + 96; cy = 1'b1;
        end
        r = t % 256; szp = 1'b1;
      end
      default: ;
    endcase
    if (o != 4) v = r;
    model[12:5] = r[7:0];
    model[4:0] = f;
    model[0] = cy;
    model[2] = ac;
    if (szp) begin
      model[4] = v >= 128;
      model[3] = v == 0;
      model[1] = ($countones(v[7:0]) % 2) == 0;
    end
  endfunction

  task automatic check(string req, logic [12:0] got, logic [12:0] exp, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got acc=%02h flags=%05b exp acc=%02h flags=%05b",
               req, what, got[12:5], got[4:0], exp[12:5], exp[4:0]);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [12:0] keep;
    logic [4:0] fl [4];
    fl[0] = 5'b00000; fl[1] = 5'b11111; fl[2] = 5'b00001; fl[3] = 5'b00100;

    repeat (2) @(negedge clk);
    check("R1", {acc_q, flags_q}, 13'd0, "reset");
    rst_n = 1'b1;

    en = 1'b1; op = 5'd0; acc_in = 8'h3C; opnd = 8'h05; flags_in = 5'd0;
    @(negedge clk);
    keep = {acc_q, flags_q};
    check("R1", keep, model(0, 8'h3C, 8'h05, 5'd0), "load");
    en = 1'b0; op = 5'd12; acc_in = 8'hA5; flags_in = 5'b11111;
    repeat (3) @(negedge clk);
    check("R1", {acc_q, flags_q}, keep, "hold with en low");
    en = 1'b1;

    for (int oi = 0; oi < 20; oi++) begin
      int o;
      o = (oi < 18) ? oi : ((oi == 18) ? 18 : 31);
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 4; k++) begin
          for (int fi = 0; fi < 4; fi++) begin
            int b;
            b = (k == 0) ? 0 : (k == 1) ? 255 : (k == 2) ? a : ((a * 29 + 7) % 256);
            op = o[4:0]; acc_in = a[7:0]; opnd = b[7:0]; flags_in = fl[fi];
            @(negedge clk);
            check(req_of(o), {acc_q, flags_q}, model(o, a, b, fl[fi]),
                  $sformatf("op=%0d a=%02h b=%02h f=%05b", o, a, b, fl[fi]));
          end
        end
      end
    end

    op = 5'd4; acc_in = 8'h10; opnd = 8'h20; flags_in = 5'd0;
    @(negedge clk);
    check("R2", {acc_q, flags_q}, {8'h10, 5'b10011}, "compare below: S, P, CY set");
    op = 5'd0; acc_in = 8'h80; opnd = 8'h80;
    @(negedge clk);
    check("R2", {acc_q, flags_q}, {8'h00, 5'b01011}, "zero sum with carry");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule